// File: doc/BRIEF.md
# Cascadable Programmable Clock Divider

A bank of post-scaler counters that run on one fast clock. Each stage counts advance cycles and derives a divided output whose period is a programmable integer number of advances, and whose high phase approximates a requested duty cycle in percent. A one-cycle tick marks each wrap of a stage's count. All stages advance on the shared enable `en_i`. Any stage after the first can instead be chained so that it advances only on its predecessor's tick, which multiplies the two division factors.

Divide and duty settings are captured only at a stage's terminal count. Software or upstream logic may therefore change them at any time without producing a truncated or stretched period. A divide value of 1 turns the stage into a gated pass-through of its advance strobe.

Top module: `clkdiv_cascade`

## Requirements
- R1: The effective divide D is `div_i` clamped to 1..512, so 0 acts as 1 and values above 512 act as 512. For D greater than 1, each period of `clk_o` and the spacing of `tick_o` is exactly D advances.
- R2: The effective duty P is `duty_i` clamped to 1..99. For D greater than 1, `clk_o` is high for the first H advances of each period, where H = floor((D*P + 50)/100), clamped to 1..D-1.
- R3: While reset is held, every stage uses D=4 and P=50 with its count at zero. `clk_o` is all ones and `tick_o` is all zeros.
- R4: When `casc_i[k]` is 1 for k of 1 or more, stage k advances only in cycles where `tick_o[k-1]` is 1. Its period is then D(k-1)*D(k) cycles of `en_i` advance. `casc_i[0]` has no effect.
- R5: New `div_i` and `duty_i` values are captured only in a cycle where that stage's `tick_o` is 1. A change in mid-period leaves the current period unchanged.
- R6: With D=1, both `clk_o[k]` and `tick_o[k]` equal the stage's advance strobe. For a stage that is not cascaded, that strobe is `en_i`.
- R7: `tick_o[k]` is high only in the last cycle of a period, and only for that one cycle. For D greater than 1, `clk_o[k]` is high in the cycle after a tick.
- R8: While `en_i` is 0, no stage advances: `tick_o` is all zeros and each `clk_o` for D greater than 1 holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable shared by all stages |
| div_i | input | N_STAGE*10 | Divide setting per stage |
| duty_i | input | N_STAGE*7 | Duty setting in percent per stage |
| casc_i | input | N_STAGE | Chain stage k to the tick of stage k-1 |
| clk_o | output | N_STAGE | Divided output per stage |
| tick_o | output | N_STAGE | Wrap pulse per stage |

## Verification
`tick_o` and `clk_o` are decoded combinationally from each stage's registered count. A tick is therefore visible in the same cycle as the terminal count, and D=1 pass-through follows `en_i` without delay. Settings applied at a tick take effect from the cycle after that tick. The bench drives inputs and samples 1 ns after each falling edge. After it sees a tick, it counts the following cycles one by one and expects the next tick in exactly the D-th of them, or the D(k-1)*D(k)-th when stages are chained, with the high cycles totalled over the same window.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int PCT_FULL = 100;
  localparam int DUTY_MIN = 1;
  localparam int DUTY_MAX = 99;
  localparam int DUTY_RST = 50;

  // rounded high time, kept inside 1..d-1
  function automatic int high_time(int d, int p);
    int h;
    if (d <= 1) return 1;
    h = (d * p + PCT_FULL / 2) / PCT_FULL;
    if (h < 1) h = 1;
    if (h > d - 1) h = d - 1;
    return h;
  endfunction
endpackage

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio
  import clkdiv_pkg::*;
#(
  parameter int MAX_DIV = 512,
  parameter int DIV_W   = 10,
  parameter int DUTY_W  = 7
) (
  input  logic [DIV_W-1:0]  div_raw_i,
  input  logic [DUTY_W-1:0] duty_raw_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [DIV_W-1:0]  hi_o
);
  int d, p, h;

  always_comb begin
    d = int'(div_raw_i);
    p = int'(duty_raw_i);
    if (d < 1) d = 1;
    if (d > MAX_DIV) d = MAX_DIV;
    if (p < DUTY_MIN) p = DUTY_MIN;
    if (p > DUTY_MAX) p = DUTY_MAX;
    h = high_time(d, p);
    div_o = DIV_W'(d);
    hi_o  = DIV_W'(h);
  end
endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
  import clkdiv_pkg::*;
#(
  parameter int MAX_DIV = 512,
  parameter int DIV_W   = 10,
  parameter int DUTY_W  = 7,
  parameter int DEF_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              clk_o,
  output logic              tick_o
);
  localparam int DEF_HI = high_time(DEF_DIV, DUTY_RST);

  logic [DIV_W-1:0] div_n, hi_n;
  logic [DIV_W-1:0] div_q, hi_q, cnt_q;
  logic             last;

  clkdiv_ratio #(
    .MAX_DIV(MAX_DIV), .DIV_W(DIV_W), .DUTY_W(DUTY_W)
  ) u_ratio (
    .div_raw_i (div_i),
    .duty_raw_i(duty_i),
    .div_o     (div_n),
    .hi_o      (hi_n)
  );

  assign last   = (cnt_q == div_q - DIV_W'(1));
  assign tick_o = adv_i & last;
  assign clk_o  = (div_q == DIV_W'(1)) ? adv_i : (cnt_q < hi_q);

  // settings are captured only on wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= DIV_W'(DEF_DIV);
      hi_q  <= DIV_W'(DEF_HI);
    end else if (tick_o) begin
      cnt_q <= '0;
      div_q <= div_n;
      hi_q  <= hi_n;
    end else if (adv_i) begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/clkdiv_cascade.sv
module clkdiv_cascade
  import clkdiv_pkg::*;
#(
  parameter int N_STAGE = 4,
  parameter int MAX_DIV = 512,
  parameter int DUTY_W  = 7,
  parameter int DEF_DIV = 4,
  localparam int DIV_W  = $clog2(MAX_DIV + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  input  logic [N_STAGE-1:0][DIV_W-1:0]    div_i,
  input  logic [N_STAGE-1:0][DUTY_W-1:0]   duty_i,
  input  logic [N_STAGE-1:0]               casc_i,
  output logic [N_STAGE-1:0]               clk_o,
  output logic [N_STAGE-1:0]               tick_o
);
  logic tick_s [N_STAGE];
  logic pred_s [N_STAGE];
  logic adv_s  [N_STAGE];

  for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign pred_s[k] = en_i;
    end else begin : g_link
      assign pred_s[k] = tick_s[k-1];
    end

    assign adv_s[k] = en_i & (~casc_i[k] | pred_s[k]);

    clkdiv_stage #(
      .MAX_DIV(MAX_DIV), .DIV_W(DIV_W), .DUTY_W(DUTY_W), .DEF_DIV(DEF_DIV)
    ) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (adv_s[k]),
      .div_i (div_i[k]),
      .duty_i(duty_i[k]),
      .clk_o (clk_o[k]),
      .tick_o(tick_s[k])
    );

    assign tick_o[k] = tick_s[k];
  end
endmodule

// File: rtl/clkdiv_cascade_chk.sv
module clkdiv_cascade_chk #(
  parameter int N_STAGE = 4,
  parameter int DIV_W   = 10,
  parameter int DUTY_W  = 7
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           en_i,
  input logic [N_STAGE-1:0][DIV_W-1:0]  div_i,
  input logic [N_STAGE-1:0][DUTY_W-1:0] duty_i,
  input logic [N_STAGE-1:0]             casc_i,
  input logic [N_STAGE-1:0]             clk_o,
  input logic [N_STAGE-1:0]             tick_o
);
  logic unused_duty;
  assign unused_duty = ^duty_i;

  p_idle_no_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> tick_o == '0);

  p_pass_through_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_o[0]) && $past(div_i[0]) == DIV_W'(1) && !casc_i[0])
      |-> clk_o[0] == en_i);

  for (genvar k = 0; k < N_STAGE; k++) begin : g_chk
    p_tick_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o[k] && div_i[k] > DIV_W'(1)) |=> !tick_o[k]);

    p_high_after_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(tick_o[k]) && $past(div_i[k]) > DIV_W'(1)) |-> clk_o[k]);

    if (k > 0) begin : g_link
      p_casc_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (casc_i[k] && !tick_o[k-1]) |-> !tick_o[k]);
    end
  end
endmodule

bind clkdiv_cascade clkdiv_cascade_chk #(
  .N_STAGE(N_STAGE), .DIV_W(DIV_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .div_i (div_i),
  .duty_i(duty_i),
  .casc_i(casc_i),
  .clk_o (clk_o),
  .tick_o(tick_o)
);

// File: tb/tb_clkdiv_cascade.sv
`timescale 1ns/1ps
module tb_clkdiv_cascade;
  localparam int NS = 4;
  localparam int DW = 10;
  localparam int PW = 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [NS-1:0][DW-1:0] div_i;
  logic [NS-1:0][PW-1:0] duty_i;
  logic [NS-1:0] casc_i;
  logic [NS-1:0] clk_o, tick_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  clkdiv_cascade dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_i(div_i),
    .duty_i(duty_i), .casc_i(casc_i), .clk_o(clk_o), .tick_o(tick_o)
  );

  // div, duty, expected period, expected high time
  localparam int VEC [12][4] = '{
    '{4, 50, 4, 2},     '{5, 50, 5, 3},     '{3, 10, 3, 1},
    '{3, 99, 3, 2},     '{10, 25, 10, 3},   '{7, 1, 7, 1},
    '{2, 50, 2, 1},     '{512, 50, 512, 256}, '{600, 50, 512, 256},
    '{100, 0, 100, 1},  '{100, 120, 100, 99}, '{9, 33, 9, 3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic wait_tick(input int k);
    int n = 0;
    do begin
      step();
      n++;
    end while (!tick_o[k] && n < 3000);
    chk(tick_o[k] == 1'b1, "sync tick", int'(tick_o[k]), 1);
  endtask

  // count high cycles and find the tick within one window
  task automatic measure(input int k, input int win, output int hi, output int first_tick,
                         output int n_tick);
    hi = 0; first_tick = -1; n_tick = 0;
    for (int i = 0; i < win; i++) begin
      step();
      hi += int'(clk_o[k]);
      if (tick_o[k]) begin
        n_tick++;
        if (first_tick < 0) first_tick = i;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi, ft, nt;
    div_i = '0; duty_i = '0; casc_i = '0;
    for (int k = 0; k < NS; k++) begin
      div_i[k] = DW'(4); duty_i[k] = PW'(50);
    end

    // R3 reset state
    repeat (3) step();
    chk(clk_o == '1, "R3 clk_o in reset", int'(clk_o), 15);
    chk(tick_o == '0, "R3 tick_o in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    step();
    chk(clk_o == '1, "R3 clk_o after reset", int'(clk_o), 15);

    en_i = 1'b1;
    // R1 R2 R7 vector table
    foreach (VEC[v]) begin
      div_i[0] = DW'(VEC[v][0]);
      duty_i[0] = PW'(VEC[v][1]);
      wait_tick(0);
      measure(0, VEC[v][2], hi, ft, nt);
      chk(ft == VEC[v][2] - 1, "R1 period", ft + 1, VEC[v][2]);
      chk(nt == 1, "R7 single tick", nt, 1);
      chk(hi == VEC[v][3], "R2 high time", hi, VEC[v][3]);
    end

    // R5 mid-period change waits for wrap
    div_i[0] = DW'(6); duty_i[0] = PW'(50);
    wait_tick(0);
    step();
    hi = int'(clk_o[0]);
    div_i[0] = DW'(3);
    measure(0, 5, ft, ft, nt);
    begin
      int h2, f2, n2;
      // re-measure cleanly: remaining 5 cycles held old period
      chk(tick_o[0] == 1'b1, "R5 old period kept", int'(tick_o[0]), 1);
      chk(nt == 1, "R5 one tick in old period", nt, 1);
      measure(0, 3, h2, f2, n2);
      chk(f2 == 2, "R5 new period", f2 + 1, 3);
      chk(h2 == 2, "R5 new high time", h2, 2);
    end

    // R8 hold while disabled
    div_i[0] = DW'(8);
    wait_tick(0);
    step(); step();
    @(negedge clk_i); en_i = 1'b0; #1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(clk_o[0] == 1'b1 && tick_o == '0, "R8 hold", int'(tick_o), 0);
    end
    @(negedge clk_i); en_i = 1'b1; #1;
    ft = -1;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) step();
      if (tick_o[0] && ft < 0) ft = i;
    end
    chk(ft == 5, "R8 resume count", ft, 5);

    // R4 cascade: 3 x 4
    div_i[0] = DW'(3); duty_i[0] = PW'(50);
    div_i[1] = DW'(4); duty_i[1] = PW'(50);
    casc_i[1] = 1'b1;
    casc_i[0] = 1'b1;
    wait_tick(1);
    wait_tick(1);
    measure(1, 12, hi, ft, nt);
    chk(ft == 11, "R4 cascade period", ft + 1, 12);
    chk(nt == 1, "R4 cascade single tick", nt, 1);
    chk(hi == 6, "R4 cascade high time", hi, 6);
    measure(0, 3, hi, ft, nt);
    chk(ft == 2, "R4 casc_i[0] no effect", ft + 1, 3);
    casc_i = '0;

    // R6 divide by one
    div_i[0] = DW'(1);
    wait_tick(0);
    begin
      bit pat [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
      foreach (pat[i]) begin
        @(negedge clk_i); en_i = pat[i]; #1;
        chk(clk_o[0] == pat[i] && tick_o[0] == pat[i], "R6 pass-through",
            int'(clk_o[0]), int'(pat[i]));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule